// File: doc/BRIEF.md
# Zero-Turnaround Synchronous SRAM Model

This block is a synthesizable behavioural model of a synchronous static RAM whose bus can alternate between reads and writes on every cycle with no idle slot between them. Commands (address, chip selects, write enable, byte write enables and the burst control) are captured on rising clock edges. Write data is not taken with its command. It follows one or two edges later, so that the data slot of a write falls exactly where the data slot of a read would fall.

A static mode input selects the timing. In registered-output timing, read data is driven after the edge that follows the command edge, and write data is taken two edges after the command. In pass-through timing, read data is driven straight after the command edge, and write data is taken on the next edge. A two-bit burst generator lets a command continue at the next address in linear or interleaved order. A clock-enable stall, an asynchronous output enable and a sleep input control the bus. The data bus is split into an input, an output and a drive-enable.

Top module: `zt_sram`

## Requirements
- R1: Registered timing: a command edge with clk_en_n=0, sleep=0, adv=0, sel1_n=0, sel2=1, sel3_n=0 and we_n=1 starts a read, and its data is on d_out with d_oe=1 from the edge after the command edge until the next edge. Reads on consecutive cycles stream without gaps.
- R2: Pass-through timing (flow_mode=1): the read data is on d_out with d_oe=1 from the command edge itself.
- R3: Registered timing: the same enables with we_n=0 start a write. Its data is sampled from d_in at the second edge after the command edge. bw_n bit i, active low, guards d_in[9i+8:9i].
- R4: Pass-through timing: write data is sampled at the first edge after the command edge.
- R5: A write command with bw_n all ones leaves the array unchanged, and the bus is not driven in its data slot.
- R6: With adv=1, the previous command type continues at the next burst address. The upper address bits are held. The two low bits step base+n mod 4 when burst_ilv=0, and base XOR n when burst_ilv=1, where n counts the continuations. we_n and addr are ignored during continuations.
- R7: With adv=0 and any chip select inactive, the cycle is a deselect and its data slot is not driven. A continuation after a deselect is also a deselect.
- R8: clk_en_n=1 freezes every register and the array, so a driven read stays driven with the same data.
- R9: oe_n=1 turns d_oe off at once without a clock. d_oe is never high in a write data slot.
- R10: sleep=1 holds d_oe low and all state frozen. Commands presented during sleep have no effect.
- R11: Registered timing: a read whose address matches the write whose data arrives on the read's data-capture edge returns that write's bytes merged over the old word.
- R12: A synchronous active-low reset empties both pipeline stages, so d_oe is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clk_en_n | input | 1 | Clock enable, active low; high stalls the block |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| adv | input | 1 | 0 loads a new command, 1 continues the burst |
| we_n | input | 1 | Write enable, active low |
| bw_n | input | BYTES | Byte write enables, active low |
| addr | input | ADDR_W | Word address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep, active high |
| flow_mode | input | 1 | 1 selects pass-through timing, 0 registered timing |
| burst_ilv | input | 1 | 1 selects interleaved burst order, 0 linear |
| d_in | input | BYTES*BYTE_W | Write data |
| d_out | output | BYTES*BYTE_W | Read data |
| d_oe | output | 1 | Drive enable for d_out |

## Verification
In registered timing, a read command can be captured on the same edge as the late data of the write just before it, to the same word. The array update and the read capture then coincide. This is provoked by a partial-byte write to a word that already holds a known value, followed at once by a read of that word. The read result must carry the new byte and the old bytes, not the stale word. A stall landing on a driven read is also provoked, and the data must hold unchanged through the stall.

// File: rtl/zt_pkg.sv
// Package for the zero-turnaround SRAM model.
// Holds the command type carried through the pipeline stages.
package zt_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } zt_op_e;

endpackage

// File: rtl/zt_cmd_decode.sv
// Command decoder.
// Turns the sampled control pins into a command type, and flags a load or a burst step.
// Assumes last_op_i holds the type of the previous accepted command (OP_IDLE after a deselect).
module zt_cmd_decode
    import zt_pkg::*;
(
    input  logic   sel1_n,
    input  logic   sel2,
    input  logic   sel3_n,
    input  logic   adv,
    input  logic   we_n,
    input  zt_op_e last_op_i,
    output zt_op_e op_o,
    output logic   load_o,
    output logic   step_o
);

    // Classify the cycle: new read/write, deselect, or continuation.
    always_comb begin
        load_o = !adv;
        step_o = adv;
        if (adv) begin
            op_o = last_op_i;
        end else if (!sel1_n && sel2 && !sel3_n) begin
            op_o = we_n ? OP_READ : OP_WRITE;
        end else begin
            op_o = OP_IDLE;
        end
    end

endmodule

// File: rtl/zt_burst_gen.sv
// Burst address generator.
// Produces the low address bits for the current command: the loaded base on a load,
// otherwise the next step of a linear or interleaved sequence that wraps after 2**CNT_W.
// Assumes en is high only on edges the block actually accepts.
module zt_burst_gen #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load,
    input  logic             step,
    input  logic             interleave,
    input  logic [CNT_W-1:0] base_i,
    output logic [CNT_W-1:0] low_o
);

    logic [CNT_W-1:0] base_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic [CNT_W-1:0] seq;

    // Next count and the address it selects in the chosen order.
    always_comb begin
        cnt_nx = cnt_q + 1'b1;
        seq    = interleave ? (base_q ^ cnt_nx) : (base_q + cnt_nx);
        low_o  = load ? base_i : seq;
    end

    // Hold the base and the step count across a burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (en) begin
            if (load) begin
                base_q <= base_i;
                cnt_q  <= '0;
            end else if (step) begin
                cnt_q <= cnt_nx;
            end
        end
    end

    // R6: each accepted continuation moves the count by exactly one.
    a_r6_step_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (en && step && !load) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R6: a load restarts the sequence at its base.
    a_r6_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (en && load) |=> (cnt_q == '0 && base_q == $past(base_i)));

endmodule

// File: rtl/zt_byte_merge.sv
// Byte merge.
// Replaces each byte of old_i whose active-low enable is low with the matching byte of new_i.
module zt_byte_merge #(
    parameter int BYTES  = 4,
    parameter int BYTE_W = 9
) (
    input  logic [BYTES*BYTE_W-1:0] old_i,
    input  logic [BYTES*BYTE_W-1:0] new_i,
    input  logic [BYTES-1:0]        bw_n_i,
    output logic [BYTES*BYTE_W-1:0] merged_o
);

    // One selector for each byte lane.
    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        assign merged_o[i*BYTE_W +: BYTE_W] =
            bw_n_i[i] ? old_i[i*BYTE_W +: BYTE_W] : new_i[i*BYTE_W +: BYTE_W];
    end

endmodule

// File: rtl/zt_sram.sv
// Zero-turnaround synchronous SRAM model.
// Two command stages. Stage 1 holds the command accepted on the last edge and stage 2 the one before.
// Pass-through timing reads and writes from stage 1. Registered timing writes from stage 2
// and registers read data out of stage 1.
// Assumes flow_mode and burst_ilv are static between resets.
module zt_sram
    import zt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4,
    parameter int BYTE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clk_en_n,
    input  logic                    sel1_n,
    input  logic                    sel2,
    input  logic                    sel3_n,
    input  logic                    adv,
    input  logic                    we_n,
    input  logic [BYTES-1:0]        bw_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    oe_n,
    input  logic                    sleep,
    input  logic                    flow_mode,
    input  logic                    burst_ilv,
    input  logic [BYTES*BYTE_W-1:0] d_in,
    output logic [BYTES*BYTE_W-1:0] d_out,
    output logic                    d_oe
);

    localparam int DATA_W  = BYTES * BYTE_W;
    localparam int DEPTH   = 1 << ADDR_W;
    localparam int BURST_W = 2;

    logic [DATA_W-1:0] mem [DEPTH];

    zt_op_e              cmd_op, last_op_q, s1_op, s2_op;
    logic                cmd_load, cmd_step, adv_en;
    logic [BURST_W-1:0]  burst_low;
    logic [ADDR_W-1:BURST_W] hi_q;
    logic [ADDR_W-1:0]   cmd_addr, s1_addr, s2_addr, wr_addr;
    logic [BYTES-1:0]    s1_bw, s2_bw, wr_bw;
    logic [DATA_W-1:0]   s2_rdata, rd_raw, rd_word, wr_old, wr_word, fwd_word;
    logic                wr_fire, fwd_hit;

    assign adv_en = !clk_en_n && !sleep;

    zt_cmd_decode u_decode (
        .sel1_n    (sel1_n),
        .sel2      (sel2),
        .sel3_n    (sel3_n),
        .adv       (adv),
        .we_n      (we_n),
        .last_op_i (last_op_q),
        .op_o      (cmd_op),
        .load_o    (cmd_load),
        .step_o    (cmd_step)
    );

    zt_burst_gen #(.CNT_W(BURST_W)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (adv_en),
        .load       (cmd_load),
        .step       (cmd_step),
        .interleave (burst_ilv),
        .base_i     (addr[BURST_W-1:0]),
        .low_o      (burst_low)
    );

    // Address of the command on this edge: new upper bits on a load, held ones in a burst.
    assign cmd_addr = {(cmd_load ? addr[ADDR_W-1:BURST_W] : hi_q), burst_low};

    // Choose which stage owns the write data slot for the selected timing.
    always_comb begin
        wr_fire = flow_mode ? (s1_op == OP_WRITE) : (s2_op == OP_WRITE);
        wr_addr = flow_mode ? s1_addr : s2_addr;
        wr_bw   = flow_mode ? s1_bw   : s2_bw;
        wr_old  = mem[wr_addr];
        rd_raw  = mem[s1_addr];
        fwd_hit = !flow_mode && wr_fire && (s1_op == OP_READ) && (wr_addr == s1_addr);
        rd_word = fwd_hit ? fwd_word : rd_raw;
    end

    zt_byte_merge #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_wr_merge (
        .old_i    (wr_old),
        .new_i    (d_in),
        .bw_n_i   (wr_bw),
        .merged_o (wr_word)
    );

    zt_byte_merge #(.BYTES(BYTES), .BYTE_W(BYTE_W)) u_fwd_merge (
        .old_i    (rd_raw),
        .new_i    (d_in),
        .bw_n_i   (wr_bw),
        .merged_o (fwd_word)
    );

    // Advance the command pipeline on every accepted edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_op     <= OP_IDLE;
            s2_op     <= OP_IDLE;
            last_op_q <= OP_IDLE;
        end else if (adv_en) begin
            s1_op     <= cmd_op;
            s2_op     <= s1_op;
            last_op_q <= cmd_op;
        end
    end

    // Address, byte enables and registered read data; no reset needed.
    always_ff @(posedge clk) begin
        if (adv_en) begin
            if (cmd_load) begin
                hi_q <= addr[ADDR_W-1:BURST_W];
            end
            s1_addr  <= cmd_addr;
            s1_bw    <= bw_n;
            s2_addr  <= s1_addr;
            s2_bw    <= s1_bw;
            s2_rdata <= rd_word;
        end
    end

    // Commit late write data into the array.
    always_ff @(posedge clk) begin
        if (rst_n && adv_en && wr_fire) begin
            mem[wr_addr] <= wr_word;
        end
    end

    // Bus drive: asynchronous gating by output enable and sleep.
    always_comb begin
        d_out = flow_mode ? rd_raw : s2_rdata;
        d_oe  = !sleep && !oe_n && (flow_mode ? (s1_op == OP_READ) : (s2_op == OP_READ));
    end

    // R1: a fully selected load with write disabled enters stage 1 as a read.
    a_r1_read_enters: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && !adv && !sel1_n && sel2 && !sel3_n && we_n) |=> (s1_op == OP_READ));

    // R7: a load with any select inactive leaves stage 1 idle.
    a_r7_deselect_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_en && !adv && (sel1_n || !sel2 || sel3_n)) |=> (s1_op == OP_IDLE));

    // R8: a stall or sleep edge keeps both stages and the read register unchanged.
    a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_en) |=> ($stable(s1_op) && $stable(s2_op) && $stable(s2_rdata)));

    // R9: the bus is never driven in a write data slot.
    a_r9_write_slot_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_mode ? (s1_op == OP_WRITE) : (s2_op == OP_WRITE)) |-> !d_oe);

    // R10: sleep keeps the bus released.
    a_r10_sleep_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> !d_oe);

endmodule

// File: tb/zt_sram_bench.sv
// Bench for zt_sram: a vector table in registered linear timing, then directed tests.
module zt_sram_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    localparam logic [35:0] A  = 36'h111111111;
    localparam logic [35:0] B  = 36'h222222222;
    localparam logic [35:0] C  = 36'h333333333;
    localparam logic [35:0] D  = 36'h0A5A5A5A5;
    localparam logic [35:0] E  = 36'h05A5A5A5A;
    localparam logic [35:0] F  = 36'h0F0F0F0F0;
    localparam logic [35:0] G  = 36'h00F0F0F0F;
    localparam logic [35:0] K0 = 36'h100000001;
    localparam logic [35:0] K1 = 36'h200000002;
    localparam logic [35:0] K2 = 36'h300000003;
    localparam logic [35:0] K3 = 36'h400000004;
    localparam logic [35:0] AC = 36'h111111133;

    typedef struct packed {
        logic        sel;
        logic        adv;
        logic        we_n;
        logic [3:0]  bw_n;
        logic [5:0]  addr;
        logic [35:0] din;
        logic        exp_oe;
        logic [35:0] exp_do;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VT [NV] = '{
        '{1'b1, 1'b0, 1'b0, 4'h0, 6'd4, 36'h0, 1'b0, 36'h0, 4'd3},   // R3 write 4
        '{1'b1, 1'b0, 1'b0, 4'h0, 6'd5, 36'h0, 1'b0, 36'h0, 4'd3},   // R3 write 5
        '{1'b1, 1'b0, 1'b1, 4'hF, 6'd4, A,     1'b0, 36'h0, 4'd9},   // R9 read 4, data A for 4
        '{1'b1, 1'b0, 1'b1, 4'hF, 6'd5, B,     1'b1, A,     4'd1},   // R1 read 5, data B for 5
        '{1'b1, 1'b0, 1'b0, 4'hE, 6'd4, 36'h0, 1'b1, B,     4'd1},   // R1 byte0 write 4
        '{1'b1, 1'b0, 1'b1, 4'hF, 6'd4, 36'h0, 1'b0, 36'h0, 4'd9},   // R9 read 4 right after
        '{1'b0, 1'b0, 1'b1, 4'hF, 6'd0, C,     1'b1, AC,    4'd11},  // R11 merged forward
        '{1'b0, 1'b1, 1'b1, 4'hF, 6'd0, 36'h0, 1'b0, 36'h0, 4'd7},   // R7 deselect slot
        '{1'b1, 1'b0, 1'b0, 4'h0, 6'd9, 36'h0, 1'b0, 36'h0, 4'd7},   // R7 continued deselect slot
        '{1'b1, 1'b1, 1'b1, 4'h0, 6'd0, 36'h0, 1'b0, 36'h0, 4'd6},   // R6 burst write -> 10
        '{1'b1, 1'b1, 1'b1, 4'h0, 6'd0, D,     1'b0, 36'h0, 4'd6},   // R6 -> 11, D for 9
        '{1'b1, 1'b1, 1'b1, 4'h0, 6'd0, E,     1'b0, 36'h0, 4'd6},   // R6 -> 8, E for 10
        '{1'b1, 1'b0, 1'b1, 4'hF, 6'd9, F,     1'b0, 36'h0, 4'd6},   // R6 read 9, F for 11
        '{1'b1, 1'b1, 1'b0, 4'hF, 6'd0, G,     1'b1, D,     4'd6},   // R6 read 10, G for 8
        '{1'b1, 1'b1, 1'b1, 4'hF, 6'd0, 36'h0, 1'b1, E,     4'd6},   // R6 read 11
        '{1'b1, 1'b1, 1'b1, 4'hF, 6'd0, 36'h0, 1'b1, F,     4'd6},   // R6 read 8 (wrap)
        '{1'b0, 1'b0, 1'b1, 4'hF, 6'd0, 36'h0, 1'b1, G,     4'd6},   // R6 wrap data
        '{1'b0, 1'b0, 1'b1, 4'hF, 6'd0, 36'h0, 1'b0, 36'h0, 4'd7}    // R7
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en_n = 1'b0;
    logic        sel1_n = 1'b1;
    logic        sel2 = 1'b1;
    logic        sel3_n = 1'b0;
    logic        adv = 1'b0;
    logic        we_n = 1'b1;
    logic [3:0]  bw_n = 4'hF;
    logic [5:0]  addr = '0;
    logic        oe_n = 1'b0;
    logic        sleep = 1'b0;
    logic        flow_mode = 1'b0;
    logic        burst_ilv = 1'b0;
    logic [35:0] d_in = '0;
    logic [35:0] d_out;
    logic        d_oe;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    zt_sram u_zt_sram (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en_n  (clk_en_n),
        .sel1_n    (sel1_n),
        .sel2      (sel2),
        .sel3_n    (sel3_n),
        .adv       (adv),
        .we_n      (we_n),
        .bw_n      (bw_n),
        .addr      (addr),
        .oe_n      (oe_n),
        .sleep     (sleep),
        .flow_mode (flow_mode),
        .burst_ilv (burst_ilv),
        .d_in      (d_in),
        .d_out     (d_out),
        .d_oe      (d_oe)
    );

    // Present one cycle of inputs, clock it, and return at the following falling edge.
    task automatic step(input logic sel, input logic a, input logic w,
                        input logic [3:0] bw, input logic [5:0] ad, input logic [35:0] din);
        sel1_n = !sel;
        adv    = a;
        we_n   = w;
        bw_n   = bw;
        addr   = ad;
        d_in   = din;
        @(posedge clk);
        @(negedge clk);
    endtask

    // Compare the observed bus against the expected drive and data.
    task automatic chk(input string req, input logic eoe, input logic [35:0] edo);
        logic [36:0] act;
        logic [36:0] exp;
        act = {d_oe, d_oe ? d_out : 36'h0};
        exp = {eoe, eoe ? edo : 36'h0};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic flow, input logic ilv);
        rst_n     = 1'b0;
        flow_mode = flow;
        burst_ilv = ilv;
        step(1'b1, 1'b0, 1'b1, 4'hF, 6'd4, 36'h0);
        step(1'b1, 1'b0, 1'b1, 4'hF, 6'd4, 36'h0);
        chk("R12 reset empties pipeline", 1'b0, 36'h0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset(1'b0, 1'b0);

        // Table: registered timing, linear bursts.
        for (int i = 0; i < NV; i++) begin
            step(VT[i].sel, VT[i].adv, VT[i].we_n, VT[i].bw_n, VT[i].addr, VT[i].din);
            chk($sformatf("R%0d vector %0d", VT[i].req, i), VT[i].exp_oe, VT[i].exp_do);
        end

        // R8 / R9 / R10 in registered timing: drive D from word 9, then stall, gate and sleep.
        step(1'b1, 1'b0, 1'b1, 4'hF, 6'd9, 36'h0);
        chk("R1 slot before data", 1'b0, 36'h0);
        step(1'b0, 1'b0, 1'b1, 4'hF, 6'd0, 36'h0);
        chk("R1 read 9 driven", 1'b1, D);
        clk_en_n = 1'b1;
        step(1'b1, 1'b0, 1'b1, 4'hF, 6'd10, 36'h0);
        chk("R8 stall keeps read", 1'b1, D);
        step(1'b1, 1'b0, 1'b0, 4'h0, 6'd10, 36'h0);
        chk("R8 second stall keeps read", 1'b1, D);
        oe_n = 1'b1;
        #1;
        chk("R9 oe_n high releases bus", 1'b0, 36'h0);
        oe_n = 1'b0;
        #1;
        chk("R9 oe_n low restores bus", 1'b1, D);
        clk_en_n = 1'b0;
        sleep    = 1'b1;
        for (int k = 0; k < 3; k++) begin
            step(1'b1, 1'b0, 1'b0, 4'h0, 6'd9, 36'h0);
            chk("R10 sleep releases bus", 1'b0, 36'h0);
        end
        sleep = 1'b0;
        #1;
        chk("R10 state held across sleep", 1'b1, D);
        step(1'b0, 1'b0, 1'b1, 4'hF, 6'd0, 36'h0);
        step(1'b1, 1'b0, 1'b1, 4'hF, 6'd9, 36'h0);
        step(1'b0, 1'b0, 1'b1, 4'hF, 6'd0, 36'h0);
        chk("R10 sleep write ignored", 1'b1, D);

        // Pass-through timing with interleaved burst from base 21 -> 21,20,23,22.
        do_reset(1'b1, 1'b1);
        step(1'b1, 1'b0, 1'b0, 4'h0, 6'd21, 36'h0);
        chk("R9 pass-through write slot quiet", 1'b0, 36'h0);
        step(1'b1, 1'b1, 1'b1, 4'h0, 6'd0, K0);
        step(1'b1, 1'b1, 1'b1, 4'h0, 6'd0, K1);
        step(1'b1, 1'b1, 1'b1, 4'h0, 6'd0, K2);
        step(1'b1, 1'b0, 1'b1, 4'hF, 6'd20, K3);
        chk("R2 R4 R6 interleaved word 20", 1'b1, K1);
        step(1'b1, 1'b0, 1'b1, 4'hF, 6'd23, 36'h0);
        chk("R6 interleaved word 23", 1'b1, K2);
        step(1'b1, 1'b0, 1'b1, 4'hF, 6'd21, 36'h0);
        chk("R4 pass-through word 21", 1'b1, K0);
        step(1'b1, 1'b0, 1'b0, 4'hF, 6'd23, 36'h0);
        chk("R5 abort slot quiet", 1'b0, 36'h0);
        step(1'b1, 1'b0, 1'b1, 4'hF, 6'd23, 36'hFFFFFFFFF);
        chk("R5 abort leaves word", 1'b1, K2);
        step(1'b1, 1'b0, 1'b1, 4'hF, 6'd22, 36'h0);
        chk("R6 interleaved word 22", 1'b1, K3);

        // Mid-run reset while driving.
        rst_n = 1'b0;
        step(1'b0, 1'b0, 1'b1, 4'hF, 6'd0, 36'h0);
        chk("R12 reset releases bus", 1'b0, 36'h0);
        rst_n = 1'b1;

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule